// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block produces the interrupt request line and the interrupt identification byte of a serial port with a 16450/16550-style register model. Each clock it looks at the interrupt enable bits, the latched line-status error bits, the receive data-ready flag, the receive FIFO occupancy against a selectable trigger level, a character-timeout counter and a transmit-empty pending flag. It then picks the highest-priority active source and registers that source's identification code.

The block also carries out the side effects of status reads. Reading the identification register can retire a pending transmit-empty interrupt. Reading the line-status or modem-status register produces a one-cycle clear pulse, which the status registers outside this block use to drop their sticky bits. The register bus decode, the FIFOs and the status registers themselves are separate blocks.

Top module: `uart_irq_ident`

## Requirements
- R1: Sources are checked in a fixed order, highest first, using these enable bits: line status (enable bit 2, any `lsr_err_i` bit set, code 0x6), received data (enable bit 0, code 0x4), character timeout (enable bit 0, code 0xC), transmit empty (enable bit 1, code 0x2) and modem status (enable bit 3, any `msr_delta_i` bit set, code 0x0). When no source is active the code is 0x1. The code reflects the inputs one clock edge after they are applied.
- R2: Received data is active only when `data_ready_i` is high and `rx_count_i` is at or above the trigger level. `trig_sel_i` 0, 1, 2 and 3 select levels 1, 4, 8 and 14.
- R3: A timeout counter advances by one per clock while `data_ready_i` is high and holds otherwise. The timeout source is active once the counter reaches `TO_MULT` times `char_clks_i`.
- R4: A receive-buffer read (`rd_rbr_i`) or a FIFO push (`rx_push_i`) returns the timeout counter to zero.
- R5: A pending flag is set by `tx_load_i` and cleared by `thr_wr_i`; a load in the same cycle wins. The transmit-empty source needs the flag, `thr_empty_i` and enable bit 1.
- R6: `iir_o` is the registered code in bits 3:0 with bits 7:6 forced to 1. A read (`rd_iir_i`) while the code is 0x2 clears the pending flag. A read while any other code is shown leaves the flag untouched.
- R7: `rd_lsr_i` produces a one-cycle `lsr_clr_o` pulse in the following cycle. `rd_msr_i` does the same on `msr_clr_o`.
- R8: `irq_o` is high exactly when bit 0 of `iir_o` is low. After reset `iir_o` is 0xC1 and `irq_o`, `lsr_clr_o` and `msr_clr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_i | input | 4 | Interrupt enables: 0 data/timeout, 1 transmit empty, 2 line status, 3 modem |
| lsr_err_i | input | 4 | Latched overrun, parity, framing and break bits |
| data_ready_i | input | 1 | Receive data-ready status |
| thr_empty_i | input | 1 | Transmit holding register empty status |
| msr_delta_i | input | 4 | Modem status change bits |
| rx_count_i | input | FIFO_CNT_W | Receive FIFO occupancy |
| trig_sel_i | input | 2 | Receive trigger level select |
| char_clks_i | input | CHAR_W | One character time in clocks |
| rd_rbr_i | input | 1 | Receive buffer read strobe |
| rd_iir_i | input | 1 | Identification register read strobe |
| rd_lsr_i | input | 1 | Line status read strobe |
| rd_msr_i | input | 1 | Modem status read strobe |
| rx_push_i | input | 1 | Character pushed into receive FIFO |
| tx_load_i | input | 1 | Character moved to the shift register |
| thr_wr_i | input | 1 | Transmit holding register write |
| iir_o | output | 8 | Identification byte as read |
| irq_o | output | 1 | Interrupt request |
| lsr_clr_o | output | 1 | Line status error clear pulse |
| msr_clr_o | output | 1 | Modem status clear pulse |

## Verification
The identification code is due one clock edge after a stimulus. The bench therefore drives on a falling edge and compares at the next falling edge. The exception is the pending flag: a load or clear takes one edge, so its visible effect appears at the second falling edge. With a character time of C clocks, the timeout code must stay absent for 4·C edges after a restart and appear on the edge after that. The bench counts those edges exactly, checking one edge before the code is due and on the edge it is due. Read clear pulses are checked on the edge after the strobe and again one edge later, to confirm the pulse has dropped.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_TXEMPTY = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_e;

    typedef struct packed {
        iid_e iid;
        logic lsr_clr;
        logic msr_clr;
    } ident_state_t;

    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        logic [4:0] lvl;
        case (sel)
            2'd0:    lvl = 5'd1;
            2'd1:    lvl = 5'd4;
            2'd2:    lvl = 5'd8;
            default: lvl = 5'd14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
    parameter int CHAR_W  = 16,
    parameter int TO_MULT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_ready_i,
    input  logic              restart_i,
    input  logic [CHAR_W-1:0] char_clks_i,
    output logic              expired_o
);
    localparam int CNT_W = CHAR_W + $clog2(TO_MULT + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(char_clks_i) * CNT_W'(TO_MULT);
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (data_ready_i && (cnt_q < limit)) begin
            cnt_d = cnt_q + 1'b1;
        end
        expired_o = (cnt_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0)); // R4
    AST_TMO_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_ready_i && !restart_i) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_load_i,
    input  logic thr_wr_i,
    input  logic rd_iir_i,
    input  logic shows_thre_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (tx_load_i) begin
            pend_d = 1'b1;
        end else if (thr_wr_i || (rd_iir_i && shows_thre_i)) begin
            pend_d = 1'b0;
        end
        pend_o = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    AST_THRE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_i |=> pend_q); // R5
    AST_THRE_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr_i && !tx_load_i) |=> !pend_q); // R5

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int FIFO_CNT_W = 5
) (
    input  logic [3:0]            ier_i,
    input  logic [3:0]            lsr_err_i,
    input  logic                  data_ready_i,
    input  logic [FIFO_CNT_W-1:0] rx_count_i,
    input  logic [1:0]            trig_sel_i,
    input  logic                  tmo_i,
    input  logic                  thr_empty_i,
    input  logic                  thre_pend_i,
    input  logic [3:0]            msr_delta_i,
    output iid_e                  iid_o
);
    localparam int EXT_W = (FIFO_CNT_W > 5) ? FIFO_CNT_W : 5;

    logic [EXT_W-1:0] cnt_ext, lvl_ext;
    logic line_act, data_act, tmo_act, tx_act, modem_act;

    always_comb begin
        cnt_ext   = EXT_W'(rx_count_i);
        lvl_ext   = EXT_W'(trig_level(trig_sel_i));
        line_act  = ier_i[2] && (|lsr_err_i);
        data_act  = ier_i[0] && data_ready_i && (cnt_ext >= lvl_ext);
        tmo_act   = ier_i[0] && tmo_i;
        tx_act    = ier_i[1] && thr_empty_i && thre_pend_i;
        modem_act = ier_i[3] && (|msr_delta_i);
        if (line_act) begin
            iid_o = IID_LINE;
        end else if (data_act) begin
            iid_o = IID_RXDATA;
        end else if (tmo_act) begin
            iid_o = IID_TIMEOUT;
        end else if (tx_act) begin
            iid_o = IID_TXEMPTY;
        end else if (modem_act) begin
            iid_o = IID_MODEM;
        end else begin
            iid_o = IID_NONE;
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int FIFO_CNT_W = 5,
    parameter int CHAR_W     = 16,
    parameter int TO_MULT    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            ier_i,
    input  logic [3:0]            lsr_err_i,
    input  logic                  data_ready_i,
    input  logic                  thr_empty_i,
    input  logic [3:0]            msr_delta_i,
    input  logic [FIFO_CNT_W-1:0] rx_count_i,
    input  logic [1:0]            trig_sel_i,
    input  logic [CHAR_W-1:0]     char_clks_i,
    input  logic                  rd_rbr_i,
    input  logic                  rd_iir_i,
    input  logic                  rd_lsr_i,
    input  logic                  rd_msr_i,
    input  logic                  rx_push_i,
    input  logic                  tx_load_i,
    input  logic                  thr_wr_i,
    output logic [7:0]            iir_o,
    output logic                  irq_o,
    output logic                  lsr_clr_o,
    output logic                  msr_clr_o
);
    ident_state_t st_d, st_q;
    iid_e         iid_next;
    logic         tmo_hit;
    logic         thre_pend;
    logic         shows_thre;

    uart_irq_tmo #(
        .CHAR_W  (CHAR_W),
        .TO_MULT (TO_MULT)
    ) tmo_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_ready_i (data_ready_i),
        .restart_i    (rd_rbr_i | rx_push_i),
        .char_clks_i  (char_clks_i),
        .expired_o    (tmo_hit)
    );

    assign shows_thre = (st_q.iid == IID_TXEMPTY);

    uart_irq_thre thre_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_load_i    (tx_load_i),
        .thr_wr_i     (thr_wr_i),
        .rd_iir_i     (rd_iir_i),
        .shows_thre_i (shows_thre),
        .pend_o       (thre_pend)
    );

    uart_irq_prio #(
        .FIFO_CNT_W (FIFO_CNT_W)
    ) prio_i (
        .ier_i        (ier_i),
        .lsr_err_i    (lsr_err_i),
        .data_ready_i (data_ready_i),
        .rx_count_i   (rx_count_i),
        .trig_sel_i   (trig_sel_i),
        .tmo_i        (tmo_hit),
        .thr_empty_i  (thr_empty_i),
        .thre_pend_i  (thre_pend),
        .msr_delta_i  (msr_delta_i),
        .iid_o        (iid_next)
    );

    always_comb begin
        st_d.iid     = iid_next;
        st_d.lsr_clr = rd_lsr_i;
        st_d.msr_clr = rd_msr_i;
        iir_o        = {2'b11, 2'b00, st_q.iid};
        irq_o        = ~st_q.iid[0];
        lsr_clr_o    = st_q.lsr_clr;
        msr_clr_o    = st_q.msr_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.iid     <= IID_NONE;
            st_q.lsr_clr <= 1'b0;
            st_q.msr_clr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_i[2] && (|lsr_err_i)) |=> (iir_o[3:0] == 4'h6)); // R1
    AST_RXDATA_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready_i |=> (iir_o[3:0] != 4'h4)); // R2
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_i == 4'h0) |=> !irq_o); // R8
    AST_LSR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lsr_i |=> lsr_clr_o); // R7
    AST_MSR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_msr_i |=> !msr_clr_o); // R7

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ier = '0, lsr_err = '0, msr_delta = '0;
    logic       data_ready = 1'b0, thr_empty = 1'b0;
    logic [4:0] rx_count = '0;
    logic [1:0] trig_sel = '0;
    logic [15:0] char_clks = 16'd8;
    logic rd_rbr = 0, rd_iir = 0, rd_lsr = 0, rd_msr = 0;
    logic rx_push = 0, tx_load = 0, thr_wr = 0;
    logic [7:0] iir;
    logic irq, lsr_clr, msr_clr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst_n(rst_n), .ier_i(ier), .lsr_err_i(lsr_err),
        .data_ready_i(data_ready), .thr_empty_i(thr_empty), .msr_delta_i(msr_delta),
        .rx_count_i(rx_count), .trig_sel_i(trig_sel), .char_clks_i(char_clks),
        .rd_rbr_i(rd_rbr), .rd_iir_i(rd_iir), .rd_lsr_i(rd_lsr), .rd_msr_i(rd_msr),
        .rx_push_i(rx_push), .tx_load_i(tx_load), .thr_wr_i(thr_wr),
        .iir_o(iir), .irq_o(irq), .lsr_clr_o(lsr_clr), .msr_clr_o(msr_clr)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check_iir(input string req, input logic [3:0] code);
        check(req, iir, 8'hC0 | {4'h0, code});
        check({req, " irq"}, {7'h0, irq}, {7'h0, code != 4'h1});
    endtask

    function automatic logic [3:0] model(input logic [3:0] en, input logic err, input logic rda,
                                         input logic txe, input logic ms);
        if (en[2] && err) return 4'h6;
        if (en[0] && rda) return 4'h4;
        if (en[1] && txe) return 4'h2;
        if (en[3] && ms)  return 4'h0;
        return 4'h1;
    endfunction

    function automatic int lvl(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        #(CLK_PERIOD * 2 + 1);
        check("R8 reset iir", iir, 8'hC1);
        check("R8 reset irq", {7'h0, irq}, 8'h00);
        check("R8 reset pulses", {6'h0, lsr_clr, msr_clr}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);

        // R1: sweep enables against source patterns; timeout held off via rd_rbr
        rd_rbr = 1; data_ready = 1; trig_sel = 0;
        tx_load = 1; tick(1); tx_load = 0;
        for (int e = 0; e < 16; e++) begin
            for (int c = 0; c < 16; c++) begin
                ier       = e[3:0];
                lsr_err   = c[0] ? (4'b0001 << (e % 4)) : 4'h0;
                rx_count  = c[1] ? 5'd1 : 5'd0;
                thr_empty = c[2];
                msr_delta = c[3] ? (4'b1000 >> (c % 4)) : 4'h0;
                tick(1);
                check_iir("R1 priority", model(e[3:0], c[0], c[1], c[2], c[3]));
            end
        end

        // R2: trigger levels
        ier = 4'h1; lsr_err = 0; msr_delta = 0; thr_empty = 0;
        for (int s = 0; s < 4; s++) begin
            for (int n = 0; n <= 16; n++) begin
                trig_sel = s[1:0]; rx_count = n[4:0];
                tick(1);
                check_iir("R2 trigger", (n >= lvl(s)) ? 4'h4 : 4'h1);
            end
        end
        data_ready = 0; rx_count = 5'd16; tick(1);
        check_iir("R2 no data ready", 4'h1);

        // R3/R4: timeout after TO_MULT*char_clks edges of data ready
        trig_sel = 2'd1; rx_count = 5'd1; data_ready = 1;
        for (int cc = 1; cc <= 4; cc++) begin
            char_clks = 16'(cc);
            rd_rbr = 0; rx_push = 1; tick(1); rx_push = 0;
            tick(4 * cc);
            check_iir("R3 timeout not yet", 4'h1);
            tick(1);
            check_iir("R3 timeout due", 4'hC);
            rd_rbr = 1; tick(1); rd_rbr = 0; tick(1);
            check_iir("R4 read restarts", 4'h1);
            data_ready = 0; tick(4 * cc + 2);
            check_iir("R3 holds without data", 4'h1);
            data_ready = 1; rd_rbr = 1; tick(1);
        end
        rd_rbr = 1;

        // R5/R6: transmit-empty pending flag
        ier = 4'h2; thr_empty = 1; rx_count = 0;
        tx_load = 1; tick(1); tx_load = 0; tick(1);
        check_iir("R5 thre set", 4'h2);
        rd_iir = 1; #1;
        check("R6 read value", iir, 8'hC2);
        tick(1); rd_iir = 0; tick(1);
        check_iir("R6 read clears", 4'h1);
        ier = 4'h6; lsr_err = 4'h2;
        tx_load = 1; tick(1); tx_load = 0; tick(1);
        check_iir("R1 line over thre", 4'h6);
        rd_iir = 1; tick(1); rd_iir = 0; lsr_err = 0; tick(2);
        check_iir("R6 other read keeps flag", 4'h2);
        thr_wr = 1; tick(1); thr_wr = 0; tick(1);
        check_iir("R5 write clears", 4'h1);
        ier = 4'h0; tx_load = 1; tick(1); tx_load = 0; tick(1);
        check_iir("R5 enable needed", 4'h1);
        ier = 4'h2; thr_empty = 0; tick(1);
        check_iir("R5 empty needed", 4'h1);

        // R7: read clear pulses
        rd_lsr = 1; #1;
        check("R7 lsr before", {7'h0, lsr_clr}, 8'h00);
        tick(1); rd_lsr = 0;
        check("R7 lsr pulse", {7'h0, lsr_clr}, 8'h01);
        tick(1);
        check("R7 lsr drops", {7'h0, lsr_clr}, 8'h00);
        rd_msr = 1; tick(1); rd_msr = 0;
        check("R7 msr pulse", {7'h0, msr_clr}, 8'h01);
        tick(1);
        check("R7 msr drops", {7'h0, msr_clr}, 8'h00);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule